// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block carries an 18-bit word between two ports, A and B, with one storage element per direction. Every bit of each direction is held by a cell that acts as a level-sensitive latch while its latch-enable is high. When the latch-enable is low, the cell becomes an edge-triggered register clocked by that direction's port clock. The latch-enable and port-clock controls are plain level inputs sampled on a fast system clock. The block finds their edges itself by comparing each sample with the one taken a cycle earlier.

Each port has separate data-in, data-out and output-enable signals in place of a tri-state pin. The A-to-B enable is active high and the B-to-A enable is active low. A per-bit "driven" qualifier on every data input lets the block keep the last actively driven value of a bit once nothing drives it. This mimics a bus keeper, so a floating bit never reaches the storage. All outputs are registered, so every effect appears one system clock after the inputs that cause it.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: `b_oe` equals the value `ab_oe` had one cycle earlier. When `ab_oe` is low, `b_oe` is deasserted whatever the other inputs are.
- R2: While `ab_le` is high, the A-to-B path is transparent. `b_dout` equals the effective A input of the previous cycle.
- R3: While `ab_le` is low, a rising edge of `ab_pclk` loads the storage with the effective A input. A rising edge means a sample of 1 after a sample of 0. The new value shows on `b_dout` one cycle later.
- R4: While `ab_le` is low and `ab_pclk` stays static (high or low), `b_dout` holds its value. This includes a fall of `ab_le` while `ab_pclk` is high.
- R5: When `ab_le` falls in a cycle where `ab_pclk` is low, the storage captures the effective A input of that cycle. The next rising port-clock edge overwrites it as normal.
- R6: The B-to-A path behaves like the A-to-B path, using `ba_le` and `ba_pclk`. Its enable `ba_oe_n` is active low: `a_oe` is the inverse of `ba_oe_n` one cycle earlier.
- R7: A data bit whose drive qualifier is 0 is taken as the last value it had while its qualifier was 1. This applies in transparent mode and on clock loads.
- R8: Every bit has its own keeper and storage. A drive mask covering only some bits updates only those bits, and the other bits keep their held values.
- R9: A synchronous active-high `rst` clears both storage elements and both keepers to zero and deasserts `a_oe` and `b_oe`.
- R10: The output enables do not affect storage. `a_dout` and `b_dout` always show the stored word, whether or not the enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_din | input | 18 | Data seen on port A |
| a_drv | input | 18 | Per-bit qualifier: 1 when the A bit is actively driven |
| a_dout | output | 18 | Word presented to port A (B-to-A storage) |
| a_oe | output | 1 | Drive enable for port A, active high |
| b_din | input | 18 | Data seen on port B |
| b_drv | input | 18 | Per-bit qualifier: 1 when the B bit is actively driven |
| b_dout | output | 18 | Word presented to port B (A-to-B storage) |
| b_oe | output | 1 | Drive enable for port B, active high |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable (high = transparent) |
| ab_pclk | input | 1 | A-to-B port clock, sampled level |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (high = transparent) |
| ba_pclk | input | 1 | B-to-A port clock, sampled level |

## Verification
The assertions assume that the surrounding logic never asserts both directions' enables in the same cycle, that is, `ab_oe` high together with `ba_oe_n` low. A dedicated property flags any such cycle. The stimulus obeys this rule by releasing one direction's enable in the same cycle, or earlier than, the cycle in which it grants the other. The data-path properties reason only about cycles in which every bit is driven, or none is. For the hold property they also assume that the port clock and latch enable are slow, level signals held for at least one system cycle, and the bench moves each of them at most once per cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // What a storage lane does on the next system clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_FOLLOW = 2'd1,
    ACT_LOAD   = 2'd2
  } act_e;
endpackage

// File: rtl/bus_keeper.sv
module bus_keeper #(
  parameter int W       = 18,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic [W-1:0] drv,
  output logic [W-1:0] eff
);
  generate
    if (HOLD_EN) begin : g_hold
      for (genvar i = 0; i < W; i++) begin : g_bit
        logic keep_q;
        always_ff @(posedge clk) begin
          if (rst)         keep_q <= 1'b0;
          else if (drv[i]) keep_q <= din[i];
        end
        assign eff[i] = drv[i] ? din[i] : keep_q;
      end
    end else begin : g_pass
      assign eff = din;
    end
  endgenerate
endmodule

// File: rtl/ctrl_edge.sv
module ctrl_edge
  import xcvr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic le,
  input  logic pclk,
  output act_e act
);
  logic le_q, pclk_q;
  logic pclk_rise, le_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      le_q   <= 1'b0;
      pclk_q <= 1'b0;
    end else begin
      le_q   <= le;
      pclk_q <= pclk;
    end
  end

  assign pclk_rise = pclk & ~pclk_q;
  assign le_fall   = le_q & ~le;

  // Transparency wins over a same-cycle clock edge.
  always_comb begin
    if (le)                    act = ACT_FOLLOW;
    else if (pclk_rise)        act = ACT_LOAD;
    else if (le_fall && !pclk) act = ACT_LOAD;
    else                       act = ACT_HOLD;
  end
endmodule

// File: rtl/dir_path.sv
module dir_path
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] eff,
  input  logic         oe_req,
  input  logic         le,
  input  logic         pclk,
  output logic [W-1:0] dout,
  output logic         oe
);
  act_e act;

  ctrl_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .le   (le),
    .pclk (pclk),
    .act  (act)
  );

  logic [W-1:0] store_q;
  logic         oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= oe_req;
      if (act != ACT_HOLD) store_q <= eff;
    end
  end

  assign dout = store_q;
  assign oe   = oe_q;
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int W       = 18,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_drv,
  output logic [W-1:0] a_dout,
  output logic         a_oe,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_drv,
  output logic [W-1:0] b_dout,
  output logic         b_oe,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_pclk,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_pclk
);
  logic [W-1:0] a_eff, b_eff;

  bus_keeper #(.W(W), .HOLD_EN(HOLD_EN)) u_keep_a (
    .clk (clk), .rst (rst), .din (a_din), .drv (a_drv), .eff (a_eff)
  );

  bus_keeper #(.W(W), .HOLD_EN(HOLD_EN)) u_keep_b (
    .clk (clk), .rst (rst), .din (b_din), .drv (b_drv), .eff (b_eff)
  );

  dir_path #(.W(W)) u_ab (
    .clk (clk), .rst (rst), .eff (a_eff), .oe_req (ab_oe),
    .le (ab_le), .pclk (ab_pclk), .dout (b_dout), .oe (b_oe)
  );

  dir_path #(.W(W)) u_ba (
    .clk (clk), .rst (rst), .eff (b_eff), .oe_req (~ba_oe_n),
    .le (ba_le), .pclk (ba_pclk), .dout (a_dout), .oe (a_oe)
  );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_din,
  input logic [W-1:0] a_drv,
  input logic [W-1:0] a_dout,
  input logic         a_oe,
  input logic [W-1:0] b_dout,
  input logic         b_oe,
  input logic         ab_oe,
  input logic         ab_le,
  input logic         ab_pclk,
  input logic         ba_oe_n
);
  logic seen;
  always_ff @(posedge clk) seen <= !rst;

  a_r1_oe_off: assert property (@(posedge clk) disable iff (rst)
    !ab_oe |=> !b_oe);
  a_r1_oe_on: assert property (@(posedge clk) disable iff (rst)
    ab_oe |=> b_oe);
  a_r2_follow: assert property (@(posedge clk) disable iff (rst)
    (ab_le && &a_drv) |=> b_dout == $past(a_din));
  a_r3_rise_load: assert property (@(posedge clk) disable iff (rst)
    (seen && !ab_le && ab_pclk && !$past(ab_pclk) && &a_drv)
      |=> b_dout == $past(a_din));
  a_r4_static_hold: assert property (@(posedge clk) disable iff (rst)
    (seen && !ab_le && !$past(ab_le) && !(ab_pclk && !$past(ab_pclk)))
      |=> $stable(b_dout));
  a_r6_oe_low_active: assert property (@(posedge clk) disable iff (rst)
    !ba_oe_n |=> a_oe);
  a_r6_oe_high_off: assert property (@(posedge clk) disable iff (rst)
    ba_oe_n |=> !a_oe);
  // R6: the two directions never contend for a port.
  a_r6_dir_excl: assert property (@(posedge clk) disable iff (rst)
    !(ab_oe && !ba_oe_n));
  a_r7_keep_follow: assert property (@(posedge clk) disable iff (rst)
    (seen && ab_le && $past(ab_le) && ~|a_drv && ~|$past(a_drv))
      |=> $stable(b_dout));
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (!a_oe && !b_oe && a_dout == '0 && b_dout == '0));
endmodule

bind bidir_reg_xcvr xcvr_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a_din   (a_din),
  .a_drv   (a_drv),
  .a_dout  (a_dout),
  .a_oe    (a_oe),
  .b_dout  (b_dout),
  .b_oe    (b_oe),
  .ab_oe   (ab_oe),
  .ab_le   (ab_le),
  .ab_pclk (ab_pclk),
  .ba_oe_n (ba_oe_n)
);

// File: tb/bidir_reg_xcvr_test.sv
module bidir_reg_xcvr_test;
  localparam int W  = 18;
  localparam int VN = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_din, a_drv, b_din, b_drv;
  logic [W-1:0] a_dout, b_dout;
  logic         a_oe, b_oe;
  logic         ab_oe, ab_le, ab_pclk, ba_oe_n, ba_le, ba_pclk;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  bidir_reg_xcvr uut (
    .clk (clk), .rst (rst),
    .a_din (a_din), .a_drv (a_drv), .a_dout (a_dout), .a_oe (a_oe),
    .b_din (b_din), .b_drv (b_drv), .b_dout (b_dout), .b_oe (b_oe),
    .ab_oe (ab_oe), .ab_le (ab_le), .ab_pclk (ab_pclk),
    .ba_oe_n (ba_oe_n), .ba_le (ba_le), .ba_pclk (ba_pclk)
  );

  // Row: {oe, le, pclk, drv_all, din[17:0], exp_oe, exp_dout[17:0]}
  localparam logic [40:0] VEC [VN] = '{
    {1'b1,1'b1,1'b0,1'b1,18'h12345,1'b1,18'h12345}, // R2
    {1'b1,1'b1,1'b0,1'b1,18'h2AAAA,1'b1,18'h2AAAA}, // R2
    {1'b1,1'b0,1'b0,1'b1,18'h15555,1'b1,18'h15555}, // R5 fall, clk low
    {1'b1,1'b0,1'b0,1'b1,18'h3FFFF,1'b1,18'h15555}, // R4 static low
    {1'b1,1'b0,1'b1,1'b1,18'h00F0F,1'b1,18'h00F0F}, // R3 rise
    {1'b1,1'b0,1'b1,1'b1,18'h3F0F0,1'b1,18'h00F0F}, // R4 static high
    {1'b0,1'b0,1'b0,1'b1,18'h11111,1'b0,18'h00F0F}, // R1 disabled
    {1'b0,1'b0,1'b1,1'b1,18'h22222,1'b0,18'h22222}, // R10 load while off
    {1'b1,1'b1,1'b1,1'b1,18'h33333,1'b1,18'h33333}, // R2
    {1'b1,1'b1,1'b1,1'b0,18'h0ABCD,1'b1,18'h33333}, // R7 keeper
    {1'b1,1'b0,1'b1,1'b0,18'h01234,1'b1,18'h33333}, // R4 fall, clk high
    {1'b1,1'b0,1'b0,1'b0,18'h2FFFF,1'b1,18'h33333}, // R4
    {1'b1,1'b0,1'b1,1'b0,18'h05555,1'b1,18'h33333}, // R7 load keeper
    {1'b1,1'b0,1'b0,1'b1,18'h1C3C3,1'b1,18'h33333}, // R4 keeper refresh
    {1'b1,1'b0,1'b1,1'b0,18'h00000,1'b1,18'h1C3C3}, // R7 load keeper
    {1'b1,1'b1,1'b0,1'b1,18'h00000,1'b1,18'h00000}  // R2
  };
  localparam logic [23:0] TAG [VN] = '{
    "R2 ", "R2 ", "R5 ", "R4 ", "R3 ", "R4 ", "R1 ", "R10",
    "R2 ", "R7 ", "R4 ", "R4 ", "R7 ", "R4 ", "R7 ", "R2 "
  };

  task automatic check(input string tag, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] mask, din, expv;
    rst = 1'b1;
    a_din = '0; a_drv = '0; b_din = '0; b_drv = '0;
    ab_oe = 1'b0; ab_le = 1'b0; ab_pclk = 1'b0;
    ba_oe_n = 1'b1; ba_le = 1'b0; ba_pclk = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 b_dout", b_dout, '0);
    check("R9 a_dout", a_dout, '0);
    check("R9 oe", {16'd0, a_oe, b_oe}, '0);
    rst = 1'b0;

    // Vector walk on the A-to-B direction.
    for (int i = 0; i < VN; i++) begin
      ab_oe   = VEC[i][40];
      ab_le   = VEC[i][39];
      ab_pclk = VEC[i][38];
      a_drv   = {W{VEC[i][37]}};
      a_din   = VEC[i][36:19];
      @(negedge clk);
      check({TAG[i], " oe"},   {17'd0, b_oe}, {17'd0, VEC[i][18]});
      check({TAG[i], " data"}, b_dout, VEC[i][17:0]);
    end

    // R9: reset clears storage and keepers.
    ab_le = 1'b1; a_drv = '1; a_din = 18'h3FFFF;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 b_dout after reset", b_dout, '0);
    check("R9 b_oe after reset", {17'd0, b_oe}, '0);
    rst = 1'b0;
    a_drv = '0; a_din = 18'h3FFFF;
    @(negedge clk);
    check("R9 keeper cleared", b_dout, '0);

    // R6: B-to-A path, active-low enable.
    ab_oe = 1'b0; ab_le = 1'b0;
    ba_oe_n = 1'b0; ba_le = 1'b1; b_drv = '1; b_din = 18'h2BEEF;
    @(negedge clk);
    check("R6 a_oe on", {17'd0, a_oe}, 18'd1);
    check("R6 transparent", a_dout, 18'h2BEEF);
    ba_le = 1'b0; ba_pclk = 1'b0; b_din = 18'h00001;
    @(negedge clk);
    check("R6 fall clk low capture", a_dout, 18'h00001);
    ba_pclk = 1'b1; b_din = 18'h3C000;
    @(negedge clk);
    check("R6 rise load", a_dout, 18'h3C000);
    b_din = 18'h12121;
    @(negedge clk);
    check("R6 static hold", a_dout, 18'h3C000);

    // R8: partial drive mask, keeper holds 12121 on undriven bits.
    mask = 18'h001FF; din = 18'h2A955;
    expv = (18'h12121 & ~mask) | (din & mask);
    ba_le = 1'b1; b_drv = mask; b_din = din;
    @(negedge clk);
    check("R8 per-bit keeper", a_dout, expv);

    // R10/R6: dropping the enable leaves stored data visible.
    ba_oe_n = 1'b1; ba_le = 1'b0; b_drv = '1; b_din = 18'h00000;
    @(negedge clk);
    check("R6 a_oe off", {17'd0, a_oe}, '0);
    check("R10 data kept when disabled", a_dout, expv);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule